// File: doc/BRIEF.md
# Oversampling UART Receiver

This block recovers characters from an asynchronous serial line. A separate baud generator supplies a one-cycle `tick` at the oversampling rate. The receiver uses that tick to find a falling edge on the line and to confirm a start bit at its half-bit point. It then samples each following bit at its centre, checks an optional parity bit and the first stop bit, and places the assembled character in a holding register. A completion flag goes high at the same time.

The character length (5 to 8 bits), parity enable and parity sense, and normal or double-speed sampling are latched when each start bit is detected. Normal sampling uses 16 ticks per bit and double speed uses 8. The host polls the completion flag and then pulses `rd_stb` to take the character, which clears the flag. Frame, parity and overrun flags are held together with the character. Dropping `rx_en` abandons any character in progress and clears the completion flag.

Top module: `uart_os_rx`

## Requirements
- R1: While the receiver is enabled and `rxd` stays high, no character is reported: `rx_done` stays 0.
- R2: A start bit is accepted only if `rxd` is still low at the half-bit sample point. A shorter low pulse returns the receiver to idle and reports nothing.
- R3: Data bits arrive LSB first. `len_sel` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. `rd_data` holds the character right-aligned, and its unused upper bits are 0.
- R4: When the stop bit has been sampled, `rd_data` takes the new character and `rx_done` becomes 1.
- R5: A one-cycle `rd_stb` clears `rx_done` and `ovr_err` on the next clock, unless a new character completes in the same cycle.
- R6: A bit lasts 16 ticks when `dbl_speed` is 0 and 8 ticks when it is 1. The bit centre is half a bit after the detected falling edge and one bit after each previous centre.
- R7: Only the first stop bit is checked. If it is sampled low, `frm_err` is 1 alongside that character; otherwise `frm_err` is 0.
- R8: With `par_en`=1, a parity bit follows the data. For `par_odd`=0 the expected parity bit is the XOR of the data bits, and for `par_odd`=1 it is the inverse. A mismatch sets `par_err` alongside the character. With `par_en`=0, `par_err` is 0.
- R9: If a character completes while `rx_done` is still 1 and no read is made in that cycle, it overwrites `rd_data` and `ovr_err` becomes 1.
- R10: While `rx_en` is 0, the line is ignored, a character in progress is abandoned, and `rx_done` is cleared. After re-enabling, the next complete frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling tick from the baud generator |
| rx_en | input | 1 | Receiver enable |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| len_sel | input | 2 | Data length code (0 to 3 gives 5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Parity sense, 1 for odd |
| rxd | input | 1 | Serial input line, idle high |
| rd_stb | input | 1 | One-cycle read of the holding register |
| rd_data | output | 8 | Received character, right-aligned |
| rx_done | output | 1 | Unread character available |
| frm_err | output | 1 | Stop bit was low for this character |
| par_err | output | 1 | Parity mismatch for this character |
| ovr_err | output | 1 | Previous unread character was overwritten |

## Verification
A faulty tick counter or sample point moves the sampling window off the bit centre. In a sweep over every character value, that shows up within one frame as shifted or duplicated bits in `rd_data`. A wrong state transition, such as a missed half-bit start check or a missed return to idle after a low stop bit, shows up as a spurious `rx_done` or a corrupted following character, at most two frames later. Flag handling errors appear one cycle after completion or after the read strobe.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_timer.sv
module uart_os_rx_timer #(
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8,
  localparam int CNT_W   = $clog2(OSR_NORM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             dbl_lat,
  input  logic             half_bit,
  output logic             smp,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FULL_N = CNT_W'(OSR_NORM - 1);
  localparam logic [CNT_W-1:0] FULL_D = CNT_W'(OSR_DBL - 1);
  localparam logic [CNT_W-1:0] HALF_N = CNT_W'(OSR_NORM / 2 - 1);
  localparam logic [CNT_W-1:0] HALF_D = CNT_W'(OSR_DBL / 2 - 1);

  logic [CNT_W-1:0] target;

  always_comb begin
    if (half_bit) target = dbl_lat ? HALF_D : HALF_N;
    else          target = dbl_lat ? FULL_D : FULL_N;
  end

  assign smp = tick && !restart && (cnt == target);

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (tick) begin
      if (cnt == target) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  // R6: the phase counter never reaches the bit length of the latched mode
  a_r6_phase_bound: assert property (@(posedge clk) disable iff (rst)
    (cnt < (dbl_lat ? CNT_W'(OSR_DBL) : CNT_W'(OSR_NORM - 1)) || (!dbl_lat && cnt == FULL_N)));
endmodule

// File: rtl/uart_os_rx_fsm.sv
module uart_os_rx_fsm
  import uart_os_rx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = 2,
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8,
  localparam int BCNT_W  = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                tick,
  input  logic                rx_s,
  input  logic                dbl_speed,
  input  logic [LEN_W-1:0]    len_sel,
  input  logic                par_en,
  input  logic                par_odd,
  output logic                frame_done,
  output logic [MAX_BITS-1:0] frame_data,
  output logic                frame_ferr,
  output logic                frame_perr
);
  localparam int MIN_BITS = MAX_BITS - (2 ** LEN_W) + 1;
  localparam int CNT_W    = $clog2(OSR_NORM);

  rx_state_e            state;
  logic                 armed;
  logic                 dbl_q, pen_q, podd_q;
  logic [BCNT_W-1:0]    nbits_q;
  logic [BCNT_W-1:0]    bitn;
  logic [MAX_BITS-1:0]  sh;
  logic                 par_acc;
  logic                 perr_q;
  logic                 restart, smp, start_det;
  logic [CNT_W-1:0]     phase;
  logic [BCNT_W-1:0]    shamt;

  assign start_det = en && (state == ST_IDLE) && tick && !rx_s && armed;
  assign restart   = !en || start_det;

  uart_os_rx_timer #(.OSR_NORM(OSR_NORM), .OSR_DBL(OSR_DBL)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .restart  (restart),
    .dbl_lat  (dbl_q),
    .half_bit (state == ST_START),
    .smp      (smp),
    .cnt      (phase)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state   <= ST_IDLE;
      armed   <= 1'b0;
      dbl_q   <= 1'b0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      nbits_q <= BCNT_W'(MAX_BITS);
      bitn    <= '0;
      sh      <= '0;
      par_acc <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rx_s) armed <= 1'b1;
          if (start_det) begin
            state   <= ST_START;
            armed   <= 1'b0;
            dbl_q   <= dbl_speed;
            pen_q   <= par_en;
            podd_q  <= par_odd;
            nbits_q <= BCNT_W'(MIN_BITS) + BCNT_W'(len_sel);
          end
        end
        ST_START: if (smp) begin
          if (!rx_s) begin
            state   <= ST_DATA;
            bitn    <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DATA: if (smp) begin
          sh      <= {rx_s, sh[MAX_BITS-1:1]};
          par_acc <= par_acc ^ rx_s;
          if (bitn == nbits_q - 1'b1) state <= pen_q ? ST_PAR : ST_STOP;
          else                        bitn  <= bitn + 1'b1;
        end
        ST_PAR: if (smp) begin
          perr_q <= rx_s ^ par_acc ^ podd_q;
          state  <= ST_STOP;
        end
        ST_STOP: if (smp) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign shamt      = BCNT_W'(MAX_BITS) - nbits_q;
  assign frame_done = en && (state == ST_STOP) && smp;
  assign frame_data = sh >> shamt;
  assign frame_ferr = !rx_s;
  assign frame_perr = perr_q;

  // R10: disabling forces the frame machine back to idle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> state == ST_IDLE);
  // R2: a high line at the half-bit point rejects the start bit
  a_r2_false_start: assert property (@(posedge clk) disable iff (rst)
    (en && state == ST_START && smp && rx_s) |=> state == ST_IDLE);
  // R1: a new frame needs a falling edge after the line was seen high
  a_r1_edge_needed: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !armed) |=> state == ST_IDLE);
endmodule

// File: rtl/uart_os_rx_hold.sv
module uart_os_rx_hold #(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                frame_done,
  input  logic [MAX_BITS-1:0] frame_data,
  input  logic                frame_ferr,
  input  logic                frame_perr,
  input  logic                rd_stb,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rx_done,
  output logic                frm_err,
  output logic                par_err,
  output logic                ovr_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rx_done <= 1'b0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
      ovr_err <= 1'b0;
    end else if (!en) begin
      rx_done <= 1'b0;
      ovr_err <= 1'b0;
    end else if (frame_done) begin
      rd_data <= frame_data;
      frm_err <= frame_ferr;
      par_err <= frame_perr;
      ovr_err <= rx_done && !rd_stb;
      rx_done <= 1'b1;
    end else if (rd_stb) begin
      rx_done <= 1'b0;
      ovr_err <= 1'b0;
    end
  end

  // R4: completion raises the flag and loads the character
  a_r4_done_sets: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (rx_done && rd_data == $past(frame_data)));
  // R5: a read without a simultaneous completion clears the flag
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !frame_done) |=> !rx_done);
  // R9: completing over an unread character flags an overrun
  a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
    (en && frame_done && rx_done && !rd_stb) |=> ovr_err);
  // R10: a disabled receiver reports nothing
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rx_done);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int MAX_BITS  = 8,
  parameter int LEN_W     = 2,
  parameter int OSR_NORM  = 16,
  parameter int OSR_DBL   = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                rx_en,
  input  logic                dbl_speed,
  input  logic [LEN_W-1:0]    len_sel,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                rxd,
  input  logic                rd_stb,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rx_done,
  output logic                frm_err,
  output logic                par_err,
  output logic                ovr_err
);
  logic                rx_s;
  logic                f_done, f_ferr, f_perr;
  logic [MAX_BITS-1:0] f_data;

  uart_os_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk (clk), .rst (rst), .din (rxd), .dout (rx_s)
  );

  uart_os_rx_fsm #(
    .MAX_BITS (MAX_BITS), .LEN_W (LEN_W),
    .OSR_NORM (OSR_NORM), .OSR_DBL (OSR_DBL)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (rx_en),
    .tick       (tick),
    .rx_s       (rx_s),
    .dbl_speed  (dbl_speed),
    .len_sel    (len_sel),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .frame_done (f_done),
    .frame_data (f_data),
    .frame_ferr (f_ferr),
    .frame_perr (f_perr)
  );

  uart_os_rx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .en         (rx_en),
    .frame_done (f_done),
    .frame_data (f_data),
    .frame_ferr (f_ferr),
    .frame_perr (f_perr),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .rx_done    (rx_done),
    .frm_err    (frm_err),
    .par_err    (par_err),
    .ovr_err    (ovr_err)
  );
endmodule

// File: tb/tb_uart_os_rx.sv
module tb_uart_os_rx;
  logic       clk = 1'b0;
  logic       rst, tick, rx_en, dbl_speed, par_en, par_odd, rxd, rd_stb;
  logic [1:0] len_sel;
  logic [7:0] rd_data;
  logic       rx_done, frm_err, par_err, ovr_err;

  int vectors = 0;
  int errors  = 0;
  int tdiv    = 1;
  int tphase  = 0;

  always #2 clk = ~clk;

  uart_os_rx dut (
    .clk (clk), .rst (rst), .tick (tick), .rx_en (rx_en),
    .dbl_speed (dbl_speed), .len_sel (len_sel), .par_en (par_en),
    .par_odd (par_odd), .rxd (rxd), .rd_stb (rd_stb),
    .rd_data (rd_data), .rx_done (rx_done), .frm_err (frm_err),
    .par_err (par_err), .ovr_err (ovr_err)
  );

  always @(negedge clk) begin
    tick   = (tphase == 0);
    tphase = (tphase + 1 >= tdiv) ? 0 : tphase + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (dbl_speed ? 8 : 16) * tdiv;
  endfunction

  task automatic hold_line(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  // pmode: 0 no parity bit, 1 correct parity, 2 wrong parity
  task automatic send(input int data, input int nb, input int pmode, input logic stopv);
    int b = bit_clks();
    logic p = 1'b0;
    hold_line(1'b0, b);
    for (int i = 0; i < nb; i++) begin
      p ^= data[i];
      hold_line(data[i], b);
    end
    if (pmode != 0) hold_line((p ^ par_odd) ^ (pmode == 2), b);
    hold_line(stopv, b);
    hold_line(1'b1, 2 * b);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R5 done cleared by read", rx_done, 0);
    chk("R5 overrun cleared by read", ovr_err, 0);
  endtask

  task automatic frame_check(input string req, input int data, input int nb,
                             input int pmode, input logic stopv);
    int mask = (1 << nb) - 1;
    send(data, nb, pmode, stopv);
    chk({req, " done"}, rx_done, 1);
    chk({req, " data"}, rd_data, data & mask);
    chk({req, " frame err"}, frm_err, !stopv);
    chk({req, " parity err"}, par_err, pmode == 2);
    chk({req, " overrun"}, ovr_err, 0);
    do_read();
  endtask

  initial begin
    rst = 1'b1; rx_en = 1'b0; dbl_speed = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    len_sel = 2'd3; rxd = 1'b1; rd_stb = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset done", rx_done, 0);
    chk("reset data", rd_data, 0);
    chk("reset flags", {frm_err, par_err, ovr_err}, 0);
    rx_en = 1'b1;

    // R1: idle line
    repeat (200) @(negedge clk);
    chk("R1 idle high no char", rx_done, 0);

    // R3 R4 R6: all bytes, 8 bits, normal speed
    for (int d = 0; d < 256; d++) frame_check("R3 R4 R6 8N1", d, 8, 0, 1'b1);

    // R6: double speed, all bytes
    dbl_speed = 1'b1;
    for (int d = 0; d < 256; d++) frame_check("R6 dbl", d, 8, 0, 1'b1);
    dbl_speed = 1'b0;

    // R3: shorter lengths
    for (int l = 0; l < 3; l++) begin
      len_sel = 2'(l);
      for (int d = 0; d < 40; d++) frame_check("R3 len", (d * 37 + 5) & 8'hff, 5 + l, 0, 1'b1);
    end
    len_sel = 2'd3;

    // R8: parity both senses, good and bad
    par_en = 1'b1;
    for (int s = 0; s < 2; s++) begin
      par_odd = s[0];
      for (int d = 0; d < 48; d++) frame_check("R8 parity", (d * 53 + 1) & 8'hff, 8, 1 + (d % 2), 1'b1);
    end
    len_sel = 2'd1;
    frame_check("R8 parity 6-bit", 6'h2b, 6, 2, 1'b1);
    par_en = 1'b0; par_odd = 1'b0; len_sel = 2'd3;

    // R7: low stop bit, line then returns high
    frame_check("R7 frame err", 8'h3c, 8, 0, 1'b0);
    frame_check("R7 after frame err", 8'hc3, 8, 0, 1'b1);

    // R2: short low pulse
    hold_line(1'b0, 5);
    hold_line(1'b1, 64);
    chk("R2 glitch rejected", rx_done, 0);
    frame_check("R2 after glitch", 8'h96, 8, 0, 1'b1);

    // R9: overrun
    send(8'h11, 8, 0, 1'b1);
    send(8'h22, 8, 0, 1'b1);
    chk("R9 overrun flag", ovr_err, 1);
    chk("R9 newer data", rd_data, 8'h22);
    chk("R9 done", rx_done, 1);
    do_read();

    // R10: disable clears done
    send(8'h44, 8, 0, 1'b1);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R10 disable clears done", rx_done, 0);
    // R10: frame ignored while disabled
    send(8'h55, 8, 0, 1'b1);
    chk("R10 ignored while off", rx_done, 0);
    // R10: abort mid-frame
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    hold_line(1'b0, 16);
    hold_line(1'b1, 16);
    hold_line(1'b0, 16);
    rx_en = 1'b0;
    hold_line(1'b1, 8);
    rx_en = 1'b1;
    hold_line(1'b1, 200);
    chk("R10 abort no char", rx_done, 0);
    frame_check("R10 after abort", 8'h5a, 8, 0, 1'b1);

    // R6: slower tick, one tick every 3 clocks
    tdiv = 3;
    for (int d = 0; d < 12; d++) frame_check("R6 tick div3", (d * 29 + 7) & 8'hff, 8, 0, 1'b1);
    tdiv = 1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule